// File: doc/BRIEF.md
# Released Descriptor Return Router

The router takes in 256-bit release descriptors, eight 32-bit words with word k on bits 32k+31..32k. For each one it picks the queue the pointed-to item must go back to, and it passes the descriptor on over a valid/ready handshake. The choice depends on two fields read together. One is the 4-bit return-manager code in bits 43:40. The other is the 3-bit item type in bits 72:70, which counts only when the manager code names the buffer manager itself (codes 0, 1, 2, 3, 12). Type values: 0 data buffer, 1 MSDU link, 2 MPDU link, 3 extension descriptor, 4 queue-extension descriptor.

If a pointer of one kind is sent to the idle list meant for the other kind, or if a code is illegal, the descriptor goes to a dedicated error queue. In that case the error flag (bit 95) is set and bits 255:252 carry an error code. A descriptor whose 40-bit address (bits 39:0) is zero is consumed and thrown away, and this sets a sticky status output. The release-source field and all other fields pass through untouched.

Output queue indices: 0 buffer idle list, 1..4 link idle lists of chips 0..3, 5 firmware, 6..12 software rings 0..6, 13 error queue. All queues share one descriptor bus, and a one-hot valid vector with one ready per queue goes with it. One holding register sits between input and output. Its controller has two states. In ST_EMPTY nothing is held: LOAD moves to ST_FULL when a non-null descriptor is taken, and IDLE/NULL stays in ST_EMPTY. In ST_FULL a descriptor is held: RELOAD stays when the held descriptor leaves and a new one is taken in the same cycle, STALL stays while the selected queue is not ready, and DRAIN returns to ST_EMPTY when the held descriptor leaves and nothing new arrives.

Top module: `desc_return_router`

## Requirements
- R1: After reset, no output valid is set, in_ready is 1 and null_drop_seen is 0.
- R2: Manager code 0 with type 0 goes to queue 0.
- R3: Manager codes 1, 2, 3 and 12 with type 1, 2 or 4 go to queues 1, 2, 3 and 4 (link idle lists of chips 0..3).
- R4: Manager code 4 goes to queue 5, and codes 5..11 go to queues 6..12. The type field is ignored for these codes.
- R5: Type 3 with a buffer-manager code (0, 1, 2, 3, 12) goes to firmware queue 5.
- R6: Code 0 with type 1, 2 or 4 goes to queue 13 with bit 95 set and bits 255:252 = 2. Codes 1, 2, 3, 12 with type 0 go to queue 13 with bit 95 set and bits 255:252 = 1.
- R7: Codes 13..15, or a buffer-manager code with type 5..7, go to queue 13 with bit 95 set and bits 255:252 = 3.
- R8: On a non-error route, bit 95 leaves cleared and every other bit is unchanged. On the error route, only bit 95 and bits 255:252 differ from the input.
- R9: A descriptor with bits 39:0 all zero is taken, produces no output, and sets null_drop_seen, which stays 1 until reset.
- R10: A descriptor taken at an edge is presented from that edge on, with exactly one valid bit set. in_ready is 1 whenever nothing is held or the held descriptor leaves in that cycle, which allows one descriptor per cycle.
- R11: While the selected queue is not ready, in_ready is 0 and the presented descriptor and queue stay unchanged. Descriptors leave in the order they were taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Router can take a descriptor |
| in_desc | input | 256 | Input release descriptor |
| out_valid | output | 14 | One-hot per-queue valid |
| out_ready | input | 14 | Per-queue ready |
| out_desc | output | 256 | Descriptor presented to the selected queue |
| null_drop_seen | output | 1 | Sticky: a null-address descriptor was dropped |

## Verification
The first stimulus is an exhaustive sweep of all 16 manager codes against all 8 types. It separates legal routes from the two mismatch errors and from the illegal-code error, and it shows whether each error code is correct. Random descriptors then run under random per-queue readiness, which exposes any reordering or lost descriptor when one queue blocks while others would accept. A final phase runs periodic full stalls with gaps in the input, which checks hold stability and backpressure. Null-address descriptors are spread through all phases to show that they are dropped and that the sticky flag is set.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int DESC_W   = 256;
    localparam int NUM_Q    = 14;
    localparam int QW       = $clog2(NUM_Q);
    localparam int ADDR_W   = 40;
    localparam int RM_LSB   = 40;
    localparam int RM_W     = 4;
    localparam int TY_LSB   = 70;
    localparam int TY_W     = 3;
    localparam int ERR_BIT  = 95;
    localparam int CODE_LSB = 252;
    localparam int CODE_W   = 4;

    localparam int Q_BUF   = 0;
    localparam int Q_LINK0 = 1;
    localparam int Q_FW    = 5;
    localparam int Q_SW0   = 6;
    localparam int Q_ERR   = 13;

    localparam logic [CODE_W-1:0] EC_BUF_TO_LINK = 4'd1;
    localparam logic [CODE_W-1:0] EC_LINK_TO_BUF = 4'd2;
    localparam logic [CODE_W-1:0] EC_ILLEGAL     = 4'd3;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_e;
endpackage

// File: rtl/rr_classify.sv
module rr_classify
    import rr_pkg::*;
(
    input  logic [DESC_W-1:0] desc_i,
    output logic              is_null_o,
    output logic [QW-1:0]     qsel_o,
    output logic [DESC_W-1:0] desc_o
);
    logic [RM_W-1:0]   rm;
    logic [TY_W-1:0]   ty;
    logic              is_bm;
    logic              is_link;
    logic              err;
    logic [CODE_W-1:0] code;
    logic [QW-1:0]     q;

    assign rm        = desc_i[RM_LSB +: RM_W];
    assign ty        = desc_i[TY_LSB +: TY_W];
    assign is_null_o = (desc_i[ADDR_W-1:0] == '0);

    always_comb begin
        is_bm   = (rm <= 4'd3) || (rm == 4'd12);
        is_link = (ty == 3'd1) || (ty == 3'd2) || (ty == 3'd4);
        err     = 1'b0;
        code    = '0;
        q       = QW'(Q_ERR);
        if (rm > 4'd12) begin
            err  = 1'b1;
            code = EC_ILLEGAL;
        end else if (is_bm && (ty > 3'd4)) begin
            err  = 1'b1;
            code = EC_ILLEGAL;
        end else if (rm == 4'd4) begin
            q = QW'(Q_FW);
        end else if (!is_bm) begin
            q = QW'(Q_SW0 + int'(rm) - 5);
        end else if (ty == 3'd3) begin
            q = QW'(Q_FW);
        end else if (rm == 4'd0) begin
            if (is_link) begin
                err  = 1'b1;
                code = EC_LINK_TO_BUF;
            end else begin
                q = QW'(Q_BUF);
            end
        end else if (!is_link) begin
            err  = 1'b1;
            code = EC_BUF_TO_LINK;
        end else if (rm == 4'd12) begin
            q = QW'(Q_LINK0 + 3);
        end else begin
            q = QW'(Q_LINK0 + int'(rm) - 1);
        end

        desc_o          = desc_i;
        desc_o[ERR_BIT] = err;
        if (err) begin
            desc_o[CODE_LSB +: CODE_W] = code;
        end
        qsel_o = q;
    end
endmodule

// File: rtl/rr_hold.sv
module rr_hold
    import rr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_null,
    input  logic [QW-1:0]     in_qsel,
    input  logic [DESC_W-1:0] in_desc,
    input  logic              sel_ready,
    output logic              in_ready,
    output logic              hold_valid,
    output logic [QW-1:0]     hold_qsel,
    output logic [DESC_W-1:0] hold_desc,
    output logic              null_seen
);
    hold_state_e state, state_nx;
    logic out_fire;
    logic take;
    logic drop;

    // output process
    always_comb begin
        hold_valid = (state == ST_FULL);
        out_fire   = hold_valid && sel_ready;
        in_ready   = (state == ST_EMPTY) || out_fire;
        take       = in_valid && in_ready && !in_null;
        drop       = in_valid && in_ready && in_null;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: state_nx = take ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nx = (out_fire && !take) ? ST_EMPTY : ST_FULL;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_qsel <= '0;
            hold_desc <= '0;
            null_seen <= 1'b0;
        end else begin
            if (take) begin
                hold_qsel <= in_qsel;
                hold_desc <= in_desc;
            end
            if (drop) null_seen <= 1'b1;
        end
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && !sel_ready) |=> (hold_valid && $stable(hold_desc) && $stable(hold_qsel))); // R11
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && !sel_ready) |-> !in_ready); // R11
    AST_NULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        null_seen |=> null_seen); // R9
    AST_NULL_NOLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_null && !hold_valid) |=> !hold_valid); // R9
endmodule

// File: rtl/desc_return_router.sv
module desc_return_router
    import rr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DESC_W-1:0] in_desc,
    output logic [NUM_Q-1:0]  out_valid,
    input  logic [NUM_Q-1:0]  out_ready,
    output logic [DESC_W-1:0] out_desc,
    output logic              null_drop_seen
);
    logic              c_null;
    logic [QW-1:0]     c_qsel;
    logic [DESC_W-1:0] c_desc;
    logic              hold_valid;
    logic [QW-1:0]     hold_qsel;
    logic [NUM_Q-1:0]  sel_oh;
    logic              sel_ready;

    rr_classify u_classify (
        .desc_i    (in_desc),
        .is_null_o (c_null),
        .qsel_o    (c_qsel),
        .desc_o    (c_desc)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_Q; g++) begin : g_qsel
            assign sel_oh[g]    = (hold_qsel == QW'(g));
            assign out_valid[g] = hold_valid && sel_oh[g];
        end
    endgenerate

    assign sel_ready = |(sel_oh & out_ready);

    rr_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_null    (c_null),
        .in_qsel    (c_qsel),
        .in_desc    (c_desc),
        .sel_ready  (sel_ready),
        .in_ready   (in_ready),
        .hold_valid (hold_valid),
        .hold_qsel  (hold_qsel),
        .hold_desc  (out_desc),
        .null_seen  (null_drop_seen)
    );

    AST_ONE_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid)); // R10
    AST_ERR_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[Q_ERR] |-> (out_desc[ERR_BIT] && (out_desc[CODE_LSB +: CODE_W] != '0))); // R6
    AST_CLEAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid[Q_ERR-1:0]) |-> !out_desc[ERR_BIT]); // R8
    AST_NO_NULL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> (out_desc[ADDR_W-1:0] != '0)); // R9
endmodule

// File: tb/tb_desc_return_router.sv
module tb_desc_return_router;
    localparam int NQ     = 14;
    localparam int NITEMS = 420;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_desc = '0;
    logic [NQ-1:0] out_valid;
    logic [NQ-1:0] out_ready = '0;
    logic [255:0] out_desc;
    logic         null_drop_seen;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int           m_q[$];
    logic [255:0] m_d[$];
    bit           exp_null = 0;

    always #2 clk = ~clk;

    desc_return_router dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_desc(in_desc), .out_valid(out_valid), .out_ready(out_ready),
        .out_desc(out_desc), .null_drop_seen(null_drop_seen)
    );

    function automatic void model(input logic [255:0] d, output int q, output logic [255:0] e);
        int rm = int'(d[43:40]);
        int ty = int'(d[72:70]);
        bit bm = (rm <= 3) || (rm == 12);
        int code = 0;
        q = 0;
        if (rm > 12)                          code = 3;
        else if (bm && ty > 4)                code = 3;
        else if (rm == 4)                     q = 5;
        else if (!bm)                         q = rm + 1;
        else if (ty == 3)                     q = 5;
        else if (rm == 0) begin
            if (ty == 0) q = 0; else code = 2;
        end else begin
            if (ty == 0) code = 1; else q = (rm == 12) ? 4 : rm;
        end
        e = d;
        e[95] = (code != 0);
        if (code != 0) begin
            q = 13;
            e[255:252] = 4'(code);
        end
    endfunction

    function automatic string tag_of(input int q, input logic [255:0] e);
        if (q == 0) return "R2";
        if (q <= 4) return "R3";
        if (q == 5) return (e[43:40] == 4'd4) ? "R4" : "R5";
        if (q <= 12) return "R4";
        return (e[255:252] == 4'd3) ? "R7" : "R6";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] make_desc(input int n);
        logic [255:0] d;
        for (int w = 0; w < 8; w++) d[32*w +: 32] = $urandom;
        if (d[39:0] == '0) d[0] = 1'b1;
        if (n < 128) begin
            d[43:40] = 4'(n % 16);
            d[72:70] = 3'(n / 16);
        end else begin
            d[43:40] = ($urandom % 5 == 0) ? 4'($urandom) : 4'($urandom % 13);
            d[72:70] = 3'($urandom % 6);
        end
        if (n % 37 == 5) d[39:0] = '0;
        return d;
    endfunction

    initial begin : watchdog
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000 && !done) begin
                fails++;
                $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin : stim
        int n = 0;
        int cyc = 0;
        int eq;
        logic [255:0] ed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(out_valid == '0, "R1", "out_valid after reset", 256'(out_valid), 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", 256'(in_ready), 1);
        check(null_drop_seen == 1'b0, "R1", "null flag after reset", 256'(null_drop_seen), 0);

        while (n < NITEMS || m_q.size() != 0 || in_valid) begin
            bit busy;
            bit ofire;
            if (cyc > 0) @(negedge clk);
            cyc++;
            // compare outputs with model
            if (m_q.size() == 0) begin
                check(out_valid == '0, "R9", "unexpected output", 256'(out_valid), 0);
            end else begin
                check(out_valid == (NQ'(1) << m_q[0]), tag_of(m_q[0], m_d[0]), "queue select",
                      256'(out_valid), 256'(NQ'(1) << m_q[0]));
                check(out_desc == m_d[0], "R8", "descriptor content", out_desc, m_d[0]);
            end
            check(null_drop_seen == exp_null, "R9", "sticky null flag",
                  256'(null_drop_seen), 256'(exp_null));

            // drive next input
            if (!in_valid || in_ready) begin
                if (n < NITEMS && !(n >= 300 && $urandom % 4 == 0)) begin
                    in_desc  = make_desc(n);
                    in_valid = 1'b1;
                    n++;
                end else begin
                    in_valid = 1'b0;
                end
            end
            if (n < 150)       out_ready = '1;
            else if (n < 300)  out_ready = NQ'($urandom);
            else               out_ready = (cyc % 8 < 5) ? '0 : '1;
            if (n >= NITEMS)   out_ready = '1;

            #1;
            busy  = (m_q.size() != 0);
            ofire = |(out_valid & out_ready);
            if (busy && !ofire)
                check(in_ready == 1'b0, "R11", "backpressure", 256'(in_ready), 0);
            else
                check(in_ready == 1'b1, "R10", "ready when free", 256'(in_ready), 1);
            if (ofire) begin
                void'(m_q.pop_front());
                void'(m_d.pop_front());
            end
            if (in_valid && in_ready) begin
                if (in_desc[39:0] == '0) begin
                    exp_null = 1;
                end else begin
                    model(in_desc, eq, ed);
                    m_q.push_back(eq);
                    m_d.push_back(ed);
                end
            end
        end
        repeat (2) @(negedge clk);
        check(out_valid == '0, "R9", "idle at end", 256'(out_valid), 0);
        check(null_drop_seen == 1'b1, "R9", "null flag held", 256'(null_drop_seen), 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule